// File: doc/BRIEF.md
# Out-of-Order Read Burst Tracker

This block keeps a small table of read requests that are in flight and pairs each returning read-data beat with the request it belongs to by transaction ID, not by arrival order. A request is stored when it is accepted, together with its ID and its length field (beats minus one). Each response beat looks up the oldest live entry with the same ID, adds to that entry's beat count and records the most severe response code so far. The entry is retired when the burst ends.

When a burst ends, a one-cycle completion pulse reports the ID, the number of beats counted and the most severe code. Flags on the pulse mark a burst whose end did not fall on the expected beat, and a beat whose ID matched no live entry. Bursts with different IDs may finish in any order. Bursts that share an ID are served oldest first. The block sits beside a read master or a bus monitor and does no data checking of its own.

Top module: `rd_id_tracker`

## Requirements
- R1: After reset the table is empty: `req_ready`=1, `full`=0, `done_valid`=0. A reset discards every live entry, so a beat for an ID requested before the reset is reported as unexpected.
- R2: A request is accepted on a cycle where `req_valid` and `req_ready` are both 1. At most `DEPTH` (default 4) entries are live. While all are live, `full`=1 and `req_ready`=0, and a request offered then is dropped.
- R3: When a burst ends correctly, `done_valid` pulses in the cycle after its final beat. The pulse carries `done_id`=the ID, `done_beats`=length field+1 (up to 256 beats) and `done_len_err`=`done_unexp`=0.
- R4: Bursts with different IDs complete in the order their final beats arrive, whatever order they were requested in.
- R5: A beat whose ID is shared by several live entries is counted against the oldest of them.
- R6: `done_resp` is the numerically largest 2-bit response code seen on any beat of the burst (0 lowest, 3 highest).
- R7: A beat with `beat_last`=1 that arrives before the expected count ends the burst. The completion reports the beats actually counted, with `done_len_err`=1.
- R8: A beat that reaches the expected count with `beat_last`=0 ends the burst with `done_len_err`=1. The entry is retired, so a later beat with that ID is reported as unexpected.
- R9: A beat whose ID matches no live entry pulses `done_valid` with `done_unexp`=1, `done_id`=that ID, `done_beats`=1 and `done_resp`=that beat's code. The table is left unchanged.
- R10: A request and the final beat of another burst may fall in the same cycle, and both take effect. A slot freed in a cycle can be filled from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Table can take a request |
| req_id | input | ID_W | ID of the request |
| req_len | input | LEN_W | Burst length field, beats minus one |
| beat_valid | input | 1 | A response beat is present |
| beat_id | input | ID_W | ID of the beat |
| beat_resp | input | 2 | Response code of the beat |
| beat_last | input | 1 | Beat is flagged as the final one |
| done_valid | output | 1 | Completion pulse |
| done_id | output | ID_W | ID of the completed burst |
| done_beats | output | LEN_W+1 | Beats counted |
| done_resp | output | 2 | Most severe response code |
| done_len_err | output | 1 | Burst ended on the wrong beat |
| done_unexp | output | 1 | Beat had no matching entry |
| full | output | 1 | All entries live |

## Verification
The two functions that can fall in the same cycle are storing a new request and retiring an entry on its final beat. The bench first fills the table. It then offers a request together with a final beat: the request must be dropped because `full` was registered high, while the retirement still completes. On the next cycle a request and another final beat are offered together again, and both must take effect. A later beat for the new ID must complete normally, which shows that the freed slot was reused and that the occupancy count stayed correct.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
    localparam int RESP_W = 2;

    function automatic logic [RESP_W-1:0] resp_worst(input logic [RESP_W-1:0] a,
                                                     input logic [RESP_W-1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rdt_free_slot.sv
module rdt_free_slot #(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] live,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
);
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!live[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rdt_oldest_hit.sv
module rdt_oldest_hit #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]            live,
    input  logic [DEPTH-1:0][ID_W-1:0]  tag,
    input  logic [DEPTH-1:0][DEPTH-1:0] older,
    input  logic [ID_W-1:0]             key,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);
    logic [DEPTH-1:0] same;
    logic [DEPTH-1:0] pick;

    // older[i][j] = 1: entry j was stored before entry i
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign same[g] = live[g] && (tag[g] == key);
        assign pick[g] = same[g] && !(|(same & older[g]));
    end

    always_comb begin
        hit     = |pick;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pick[i]) hit_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (!$isunknown(pick)) begin
            assert_single_pick_R5: assert ($onehot0(pick))
                else $error("more than one oldest entry selected");
        end
    end
endmodule

// File: rtl/rd_id_tracker.sv
module rd_id_tracker #(
    parameter int ID_W  = 4,
    parameter int LEN_W = 8,
    parameter int DEPTH = 4,
    localparam int CNT_W = LEN_W + 1,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ID_W-1:0]           req_id,
    input  logic [LEN_W-1:0]          req_len,
    input  logic                      beat_valid,
    input  logic [ID_W-1:0]           beat_id,
    input  logic [rdt_pkg::RESP_W-1:0] beat_resp,
    input  logic                      beat_last,
    output logic                      done_valid,
    output logic [ID_W-1:0]           done_id,
    output logic [CNT_W-1:0]          done_beats,
    output logic [rdt_pkg::RESP_W-1:0] done_resp,
    output logic                      done_len_err,
    output logic                      done_unexp,
    output logic                      full
);
    import rdt_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0]              live;
        logic [DEPTH-1:0][ID_W-1:0]    tag;
        logic [DEPTH-1:0][LEN_W-1:0]   len;
        logic [DEPTH-1:0][CNT_W-1:0]   cnt;
        logic [DEPTH-1:0][RESP_W-1:0]  worst;
        logic [DEPTH-1:0][DEPTH-1:0]   older;
        logic                          o_vld;
        logic [ID_W-1:0]               o_id;
        logic [CNT_W-1:0]              o_beats;
        logic [RESP_W-1:0]             o_resp;
        logic                          o_len_err;
        logic                          o_unexp;
    } state_t;

    state_t st_d, st_q;

    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             req_fire;

    rdt_free_slot #(.DEPTH(DEPTH)) u_free (
        .live     (st_q.live),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    rdt_oldest_hit #(.DEPTH(DEPTH), .ID_W(ID_W)) u_hit (
        .live    (st_q.live),
        .tag     (st_q.tag),
        .older   (st_q.older),
        .key     (beat_id),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    assign req_fire = req_valid && any_free;

    always_comb begin
        logic [CNT_W-1:0]  n_cnt;
        logic [CNT_W-1:0]  want;
        logic [RESP_W-1:0] w;
        logic              ends;

        st_d           = st_q;
        st_d.o_vld     = 1'b0;
        st_d.o_len_err = 1'b0;
        st_d.o_unexp   = 1'b0;
        n_cnt = st_q.cnt[hit_idx] + CNT_W'(1);
        want  = CNT_W'(st_q.len[hit_idx]) + CNT_W'(1);
        w     = resp_worst(st_q.worst[hit_idx], beat_resp);
        ends  = beat_last || (n_cnt == want);

        if (beat_valid) begin
            if (hit) begin
                if (ends) begin
                    st_d.live[hit_idx] = 1'b0;
                    st_d.o_vld         = 1'b1;
                    st_d.o_id          = beat_id;
                    st_d.o_beats       = n_cnt;
                    st_d.o_resp        = w;
                    st_d.o_len_err     = !beat_last || (n_cnt != want);
                end else begin
                    st_d.cnt[hit_idx]   = n_cnt;
                    st_d.worst[hit_idx] = w;
                end
            end else begin
                st_d.o_vld   = 1'b1;
                st_d.o_unexp = 1'b1;
                st_d.o_id    = beat_id;
                st_d.o_beats = CNT_W'(1);
                st_d.o_resp  = beat_resp;
            end
        end

        if (req_fire) begin
            st_d.live[free_idx]  = 1'b1;
            st_d.tag[free_idx]   = req_id;
            st_d.len[free_idx]   = req_len;
            st_d.cnt[free_idx]   = '0;
            st_d.worst[free_idx] = '0;
            for (int i = 0; i < DEPTH; i++) begin
                st_d.older[i][free_idx] = 1'b0;
            end
            st_d.older[free_idx] = st_q.live;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready    = any_free;
    assign full         = &st_q.live;
    assign done_valid   = st_q.o_vld;
    assign done_id      = st_q.o_id;
    assign done_beats   = st_q.o_beats;
    assign done_resp    = st_q.o_resp;
    assign done_len_err = st_q.o_len_err;
    assign done_unexp   = st_q.o_unexp;

    // R2: a full table does not grow
    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && req_valid) |=> ($countones(st_q.live) <= $past($countones(st_q.live))))
        else $error("occupancy grew while full");

    // R3: a completion always follows a beat on the previous cycle
    assert_done_after_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && done_valid |-> $past(beat_valid))
        else $error("completion without a beat");

    // R7: a clean completion needs the last flag on its final beat
    assert_clean_needs_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_len_err && !done_unexp) |-> $past(beat_last))
        else $error("clean completion without last flag");

    // R9: an unmatched beat with no request leaves the table alone
    assert_unexp_keeps_table_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !hit && !req_fire) |=> (st_q.live == $past(st_q.live)))
        else $error("unmatched beat changed the table");

    // R8: a completed burst never reports zero beats
    assert_nonzero_beats_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_beats != '0))
        else $error("completion with zero beats");
endmodule

// File: tb/tb_rd_id_tracker.sv
module tb_rd_id_tracker;
    localparam int ID_W = 4;
    localparam int LEN_W = 8;
    localparam int CNT_W = LEN_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ID_W-1:0] req_id = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic beat_valid = 1'b0;
    logic [ID_W-1:0] beat_id = '0;
    logic [1:0] beat_resp = '0;
    logic beat_last = 1'b0;
    logic done_valid;
    logic [ID_W-1:0] done_id;
    logic [CNT_W-1:0] done_beats;
    logic [1:0] done_resp;
    logic done_len_err, done_unexp, full;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rd_id_tracker #(.ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_len(req_len),
        .beat_valid(beat_valid), .beat_id(beat_id), .beat_resp(beat_resp), .beat_last(beat_last),
        .done_valid(done_valid), .done_id(done_id), .done_beats(done_beats),
        .done_resp(done_resp), .done_len_err(done_len_err), .done_unexp(done_unexp),
        .full(full)
    );

    typedef struct packed {
        logic [3:0]       rq;
        logic             rv;
        logic [ID_W-1:0]  rid;
        logic [LEN_W-1:0] rlen;
        logic             bv;
        logic [ID_W-1:0]  bid;
        logic [1:0]       br;
        logic             bl;
        logic             ev;
        logic [ID_W-1:0]  eid;
        logic [CNT_W-1:0] eb;
        logic [1:0]       er;
        logic             el;
        logic             eu;
        logic             ef;
    } step_t;

    localparam int NSTEP = 24;
    //  rq rv rid rlen bv bid br bl  ev eid eb er el eu ef
    localparam step_t TBL [NSTEP] = '{
        '{2, 1, 1, 1,  0, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0},   // R2 store id1 len1
        '{2, 1, 2, 0,  0, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0},   // R2 store id2 len0
        '{2, 1, 1, 2,  0, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0},   // R2 store second id1 len2
        '{4, 0, 0, 0,  1, 2, 0, 1,  1, 2, 1, 0, 0, 0, 0},   // R4 id2 finishes first
        '{5, 0, 0, 0,  1, 1, 2, 0,  0, 0, 0, 0, 0, 0, 0},   // R5 beat goes to older id1
        '{6, 0, 0, 0,  1, 1, 1, 1,  1, 1, 2, 2, 0, 0, 0},   // R6 worst of 2,1
        '{5, 0, 0, 0,  1, 1, 0, 0,  0, 0, 0, 0, 0, 0, 0},   // R5 now the younger id1
        '{6, 0, 0, 0,  1, 1, 3, 0,  0, 0, 0, 0, 0, 0, 0},
        '{6, 0, 0, 0,  1, 1, 0, 1,  1, 1, 3, 3, 0, 0, 0},   // R6 worst of 0,3,0
        '{2, 1, 3, 0,  0, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0},
        '{2, 1, 4, 0,  0, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0},
        '{2, 1, 5, 0,  0, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0},
        '{2, 1, 6, 0,  0, 0, 0, 0,  0, 0, 0, 0, 0, 0, 1},   // R2 table full
        '{2, 1, 7, 0,  0, 0, 0, 0,  0, 0, 0, 0, 0, 0, 1},   // R2 dropped while full
        '{2, 0, 0, 0,  1, 7, 0, 1,  1, 7, 1, 0, 0, 1, 1},   // R2 id7 was never stored
        '{10, 1, 8, 0, 1, 3, 0, 1,  1, 3, 1, 0, 0, 0, 0},   // R10 retire, request refused
        '{10, 1, 8, 0, 1, 4, 0, 1,  1, 4, 1, 0, 0, 0, 0},   // R10 retire and store together
        '{3, 0, 0, 0,  1, 8, 1, 1,  1, 8, 1, 1, 0, 0, 0},   // R3 id8 was stored
        '{8, 0, 0, 0,  1, 5, 0, 0,  1, 5, 1, 0, 1, 0, 0},   // R8 count reached, no last
        '{8, 0, 0, 0,  1, 5, 2, 1,  1, 5, 1, 2, 0, 1, 0},   // R8 entry gone
        '{7, 1, 9, 3,  0, 0, 0, 0,  0, 0, 0, 0, 0, 0, 0},
        '{7, 0, 0, 0,  1, 9, 2, 1,  1, 9, 1, 2, 1, 0, 0},   // R7 last after 1 of 4
        '{9, 0, 0, 0,  1, 9, 0, 1,  1, 9, 1, 0, 0, 1, 0},   // R9 unmatched id
        '{3, 0, 0, 0,  1, 6, 0, 1,  1, 6, 1, 0, 0, 0, 0}    // R3 id6 completes
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; beat_valid = 1'b0; beat_last = 1'b0; beat_resp = '0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 full", 64'(full), 64'd0);
        check("R1 done_valid", 64'(done_valid), 64'd0);

        for (int s = 0; s < NSTEP; s++) begin
            req_valid  = TBL[s].rv;
            req_id     = TBL[s].rid;
            req_len    = TBL[s].rlen;
            beat_valid = TBL[s].bv;
            beat_id    = TBL[s].bid;
            beat_resp  = TBL[s].br;
            beat_last  = TBL[s].bl;
            @(posedge clk);
            #1;
            check($sformatf("R%0d step%0d full", TBL[s].rq, s), 64'(full), 64'(TBL[s].ef));
            if (TBL[s].ev) begin
                check($sformatf("R%0d step%0d done", TBL[s].rq, s),
                      {done_valid, done_id, done_beats, done_resp, done_len_err, done_unexp},
                      {1'b1, TBL[s].eid, TBL[s].eb, TBL[s].er, TBL[s].el, TBL[s].eu});
            end else begin
                check($sformatf("R%0d step%0d no done", TBL[s].rq, s), 64'(done_valid), 64'd0);
            end
        end
        idle_inputs();

        // R3 longest burst: 256 beats, last flag on the final one
        req_valid = 1'b1; req_id = 4'd11; req_len = 8'd255;
        @(posedge clk); #1;
        req_valid = 1'b0;
        for (int b = 0; b < 256; b++) begin
            beat_valid = 1'b1; beat_id = 4'd11; beat_resp = (b == 100) ? 2'd1 : 2'd0;
            beat_last = (b == 255);
            @(posedge clk); #1;
            if (b < 255 && done_valid) begin
                check("R3 early completion in long burst", 64'(done_valid), 64'd0);
            end
        end
        check("R3 long burst done",
              {done_valid, done_id, done_beats, done_resp, done_len_err, done_unexp},
              {1'b1, 4'd11, 9'd256, 2'd1, 1'b0, 1'b0});
        idle_inputs();
        @(posedge clk); #1;
        check("R3 pulse lasts one cycle", 64'(done_valid), 64'd0);

        // R1 reset discards live entries
        req_valid = 1'b1; req_id = 4'd12; req_len = 8'd0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        check("R1 ready after reset", 64'(req_ready), 64'd1);
        beat_valid = 1'b1; beat_id = 4'd12; beat_last = 1'b1;
        @(posedge clk); #1;
        check("R1 entry dropped by reset",
              {done_valid, done_id, done_unexp}, {1'b1, 4'd12, 1'b1});
        idle_inputs();
        @(posedge clk); #1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule